// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Front End

This block sits between a memory core and an 8-bit microcontroller that time-shares its low address bits and its data on one bus. The controller places the low address byte on the shared bus and the high address bits on separate pins. It then raises an active-low address strobe, and the block keeps the full 13-bit address. After that, an active-low data strobe and a read/write select run the data phase. A read starts when the data strobe falls. A write is taken when the data strobe rises.

Every bus input is asynchronous to the block. Each one passes through a synchroniser in the system clock domain, and the strobe edges are found there. The core sees a read address with a one-cycle read pulse, and a one-cycle write pulse that carries the latched address and the write byte. Read data from the core is put back onto the shared bus through a split output and enable. The block asserts that enable only during a qualified read. With chip enable low the block is idle and never drives the bus.

Top module: `muxbus_front`

## Requirements
- R1: While the address strobe is low, `rd_addr` follows `{hi_addr, bus_in}` within four clock cycles.
- R2: Once the address strobe has risen, `rd_addr` and `wr_addr` stay at the last captured value, however the shared bus or `hi_addr` change afterwards.
- R3: With `ce` high and `rw` high (1 = read), a falling data strobe produces exactly one single-cycle `rd_req`. Within four cycles `bus_oe` is high and `bus_out` carries the core's `rd_data` for the latched address.
- R4: After the data strobe rises, `bus_oe` is low within four cycles.
- R5: While `ce` is low, `bus_oe`, `rd_req` and `wr_req` stay low whatever the strobes do.
- R6: With `ce` high and `rw` low, a rising data strobe produces exactly one `wr_req` pulse. It carries the latched address and the byte on the shared bus at that edge.
- R7: `wr_req` never lasts more than one cycle and is never high while `bus_oe` is high.
- R8: A data strobe fall during a write, or a rise during a read, issues no write and enables no output.
- R9: During and directly after reset, `bus_oe`, `rd_req` and `wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable, active high |
| as_n | input | 1 | Address strobe, active low; address captured on its rise |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| hi_addr | input | 5 | High address bits |
| bus_in | input | 8 | Shared address/data bus, input side |
| bus_out | output | 8 | Shared bus, output side |
| bus_oe | output | 1 | Output enable for the shared bus |
| rd_req | output | 1 | One-cycle read request to the core |
| rd_addr | output | 13 | Latched address presented to the core |
| rd_data | input | 8 | Read data from the core |
| wr_req | output | 1 | One-cycle write request to the core |
| wr_addr | output | 13 | Write address |
| wr_data | output | 8 | Write data |

## Verification
The assertions check the following on every cycle. The address must stay frozen while the synchronised address strobe is high. The output enable may rise only together with a read request. The output enable must fall once chip enable drops. Write pulses must last one cycle and never overlap a driven bus. Other behaviour only the bench's transactions can show. That covers transparent address tracking, the exact captured address and data, and the values presented on a read. It also covers strobe edges in the wrong direction, and silence under a low chip enable. The bench drives these through random mixes of reads, writes and deselected cycles.

// File: rtl/muxbus_front.sv
module muxbus_front #(
  parameter int LO_W = 8,
  parameter int HI_W = 5,
  parameter int SYNC_STAGES = 2,
  localparam int AW = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            as_n,
  input  logic            ds_n,
  input  logic            rw,
  input  logic [HI_W-1:0] hi_addr,
  input  logic [LO_W-1:0] bus_in,
  output logic [LO_W-1:0] bus_out,
  output logic            bus_oe,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic [LO_W-1:0] rd_data,
  output logic            wr_req,
  output logic [AW-1:0]   wr_addr,
  output logic [LO_W-1:0] wr_data
);

  localparam int SW = 4 + AW;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {AW{1'b0}}};

  logic [SW-1:0] stage_q [SYNC_STAGES];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[g] <= SYNC_RST;
          else        stage_q[g] <= {ce, as_n, ds_n, rw, hi_addr, bus_in};
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[g] <= SYNC_RST;
          else        stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  logic ce_s, as_s, ds_s, rw_s;
  logic [AW-1:0] abus_s;
  assign {ce_s, as_s, ds_s, rw_s, abus_s} = stage_q[SYNC_STAGES-1];

  logic ds_prev;
  logic [AW-1:0] addr_q;
  logic rd_act_q, rd_req_q, wr_req_q;
  logic [LO_W-1:0] wr_data_q;

  wire ds_fall = ds_prev & ~ds_s;
  wire ds_rise = ~ds_prev & ds_s;
  wire rd_cond = ce_s & rw_s & ~ds_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_prev   <= 1'b1;
      addr_q    <= '0;
      rd_act_q  <= 1'b0;
      rd_req_q  <= 1'b0;
      wr_req_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      ds_prev  <= ds_s;
      if (!as_s) addr_q <= abus_s;
      rd_req_q <= rd_cond & ds_fall;
      rd_act_q <= rd_cond & (rd_act_q | ds_fall);
      wr_req_q <= ce_s & ~rw_s & ds_rise;
      if (ce_s & ~rw_s & ds_rise) wr_data_q <= abus_s[LO_W-1:0];
    end
  end

  assign rd_addr = addr_q;
  assign wr_addr = addr_q;
  assign rd_req  = rd_req_q;
  assign wr_req  = wr_req_q;
  assign wr_data = wr_data_q;
  assign bus_oe  = rd_act_q;
  assign bus_out = rd_data;

endmodule

module muxbus_front_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          as_s,
  input logic          ce_s,
  input logic [AW-1:0] rd_addr,
  input logic          rd_req,
  input logic          wr_req,
  input logic          bus_oe
);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (as_s && $past(as_s)) |-> $stable(rd_addr));

  assert_oe_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> rd_req);

  assert_ce_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (!bus_oe && !wr_req && !rd_req));

  assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  assert_wr_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !bus_oe);

endmodule

bind muxbus_front muxbus_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_s(as_s), .ce_s(ce_s),
  .rd_addr(rd_addr), .rd_req(rd_req), .wr_req(wr_req), .bus_oe(bus_oe)
);

// File: tb/tb_muxbus_front.sv
module tb_muxbus_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, as_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [4:0] hi_addr = '0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out, rd_data, wr_data;
  logic bus_oe, rd_req, wr_req;
  logic [12:0] rd_addr, wr_addr;

  int vectors = 0, errors = 0, cycles = 0;
  int wr_cnt = 0, rd_cnt = 0, r7_bad = 0;
  logic [12:0] last_wa;
  logic [7:0]  last_wd;
  logic prev_wr = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] core_byte(input logic [12:0] a);
    return a[7:0] ^ {3'b0, a[12:8]} ^ 8'h5A;
  endfunction

  assign rd_data = core_byte(rd_addr);

  muxbus_front dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .as_n(as_n), .ds_n(ds_n), .rw(rw),
    .hi_addr(hi_addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_req) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
      if (rd_req) rd_cnt++;
      if ((wr_req && bus_oe) || (wr_req && prev_wr)) r7_bad++;
      prev_wr = wr_req;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  task automatic bus_cycle(input logic c, input logic r, input logic [12:0] a, input logic [7:0] d);
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    ce = c; rw = r; as_n = 1'b0; hi_addr = a[12:8]; bus_in = a[7:0];
    wait_n(5);
    chk("R1 transparent address", rd_addr, a);
    as_n = 1'b1;
    wait_n(4);
    bus_in = r ? $urandom() : d;
    hi_addr = $urandom();
    wait_n(4);
    chk("R2 address held", rd_addr, a);
    ds_n = 1'b0;
    wait_n(5);
    if (c && r) begin
      chk("R3 oe on read", bus_oe, 1);
      chk("R3 read data", bus_out, core_byte(a));
      chk("R3 one rd_req", rd_cnt - r0, 1);
    end else begin
      chk(c ? "R8 no drive on write" : "R5 idle no drive", bus_oe, 0);
      chk(c ? "R8 no write on fall" : "R5 no rd_req", (wr_cnt - w0) + (rd_cnt - r0), 0);
    end
    ds_n = 1'b1;
    wait_n(5);
    chk("R4 oe released", bus_oe, 0);
    if (c && !r) begin
      chk("R6 one write", wr_cnt - w0, 1);
      chk("R6 write addr", last_wa, a);
      chk("R6 write data", last_wd, d);
    end else begin
      chk(c ? "R8 no write on read" : "R5 no write", wr_cnt - w0, 0);
    end
    wait_n(2);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    wait_n(3);
    chk("R9 oe in reset", bus_oe, 0);
    chk("R9 wr in reset", wr_req, 0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R9 oe after reset", bus_oe, 0);
    chk("R9 reqs after reset", {rd_req, wr_req}, 0);
    bus_cycle(1'b1, 1'b0, 13'h0000, 8'h00);
    bus_cycle(1'b1, 1'b0, 13'h1FFF, 8'hFF);
    bus_cycle(1'b1, 1'b1, 13'h1FFF, 8'h00);
    bus_cycle(1'b1, 1'b1, 13'h1000, 8'h00);
    bus_cycle(1'b0, 1'b1, 13'h0AAA, 8'h00);
    bus_cycle(1'b0, 1'b0, 13'h0555, 8'hA5);
    for (int k = 0; k < 60; k++) begin
      logic c, r;
      c = ($urandom() % 4) != 0;
      r = $urandom() % 2;
      bus_cycle(c, r, 13'($urandom()), 8'($urandom()));
    end
    chk("R7 write pulse shape", r7_bad, 0);
    done = 1;
    finish_run();
  end
endmodule